// File: doc/BRIEF.md
# SD Card SPI Byte Engine

This block is a byte-wide SPI master that a CPU drives through four small registers in order to talk to an SD card. A write to the data port shifts the written byte out on MOSI and, at the same time, clocks a byte in from MISO. A read of the same port returns the byte captured by the most recent completed transfer.

A second data address serves streaming reads. Reading it returns the last received byte and also starts a new transfer that sends 0xFF. A read loop therefore needs only one bus access per byte. A control register drives the card's active-low select and holds two speed bits. A status register shows the engine's busy flag and the synchronized card-detect and write-protect inputs.

SCK is derived from the system clock by a fixed divide, `SCK_HALF_DIV` clock cycles per half period. The engine uses SPI mode 0 and sends the MSB first. A start request made while a transfer is running is dropped.

Top module: `sdspi_engine`

## Requirements
- R1: After reset, sd_cs_n is 1, sd_sck is 0, sd_mosi is 1 and xfer_busy is 0. Reading address 0 gives 0x01, reading address 2 gives 0x00, and status bit 0 reads 0.
- R2: A write to address 0 (control) stores bus_wdata[2:0]. From the next cycle sd_cs_n equals the stored bit 0. Reading address 0 returns {5'b0, stored bits}, and no other access changes sd_cs_n.
- R3: Reading address 1 (status) returns bit 0 = busy, bit 1 = card detect and bit 2 = write protect, with bits 7:3 zero. Each input passes through two flip-flops, so a change is visible two clock edges after it is applied.
- R4: A write to address 2 while idle starts a transfer of bus_wdata in SPI mode 0, MSB first. SCK is low when idle, MOSI changes only while SCK is low, and MOSI is 1 when idle.
- R5: xfer_busy rises at the clock edge that accepts the start. It stays high for exactly 16*SCK_HALF_DIV cycles, and sd_sck makes exactly 8 pulses during that time, each half period lasting SCK_HALF_DIV cycles.
- R6: Reading address 2 returns the byte sampled from MISO (MSB first, on SCK rising edges) in the last completed transfer, and the read starts no transfer.
- R7: Reading address 3 returns the last received byte and, if idle, starts a transfer that sends 0xFF.
- R8: A write to address 2 or a read of address 3 during a transfer is ignored. The running transfer keeps its byte and length, and the received byte is not replaced by the ignored request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 read-and-restart |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sd_sck | output | 1 | SPI clock to card |
| sd_mosi | output | 1 | Serial data to card |
| sd_miso | input | 1 | Serial data from card |
| sd_cs_n | output | 1 | Card select, active low |
| sd_detect | input | 1 | Card-detect input, asynchronous |
| sd_wprot | input | 1 | Write-protect input, asynchronous |
| xfer_busy | output | 1 | High while a byte transfer runs |

## Verification
Register reads are combinational, so the bench samples bus_rdata in the same cycle it drives the address, half a clock before the edge that applies any side effect. A control write shows on sd_cs_n after one edge, and a status input change shows on a read after two edges. The bench therefore applies each change on a falling edge and reads only after that many rising edges. Transfer length is taken as the difference of a free-running cycle counter between the falling edge after the accepting clock edge and the first falling edge with busy low, which must equal 16*SCK_HALF_DIV. A bench SPI slave model supplies MISO bits and captures MOSI bits, so sent and received bytes are compared only after busy has dropped.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_DRST = 2'd3
  } reg_addr_e;

  localparam int CTRL_W     = 3;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_CD    = 1;
  localparam int STAT_WP    = 2;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'b001;

  // Clock cycles one byte transfer occupies for a given half-period divide.
  function automatic int unsigned xfer_cycles(input int unsigned half_div);
    return 16 * half_div;
  endfunction

  // Status byte assembly.
  function automatic logic [7:0] stat_word(input logic busy, input logic cd,
                                           input logic wp);
    logic [7:0] w;
    w = 8'h00;
    w[STAT_BUSY] = busy;
    w[STAT_CD]   = cd;
    w[STAT_WP]   = wp;
    return w;
  endfunction

  // Control byte as seen on a read.
  function automatic logic [7:0] ctrl_word(input logic [CTRL_W-1:0] c);
    return {{(8-CTRL_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/sdspi_sync.sv
module sdspi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/sdspi_regs.sv
module sdspi_regs
  import sdspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              busy,
  input  logic              cd_sync,
  input  logic              wp_sync,
  input  logic [7:0]        rx_byte,
  output logic              start_req,
  output logic              start_fill,
  output logic              cs_n,
  output logic [7:0]        rdata
);

  logic [CTRL_W-1:0] ctrl_q;
  reg_addr_e         addr;
  logic              ctrl_wr;
  logic              send_wr;
  logic              rst_rd;

  assign addr    = reg_addr_e'(bus_addr);
  assign ctrl_wr = bus_sel &&  bus_wr && (addr == REG_CTRL);
  assign send_wr = bus_sel &&  bus_wr && (addr == REG_DATA);
  assign rst_rd  = bus_sel && !bus_wr && (addr == REG_DRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= ctrl_wdata;
  end

  assign cs_n       = ctrl_q[0];
  assign start_req  = send_wr || rst_rd;
  assign start_fill = rst_rd;

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = ctrl_word(ctrl_q);
      REG_STAT: rdata = stat_word(busy, cd_sync, wp_sync);
      REG_DATA,
      REG_DRST: rdata = rx_byte;
      default:  rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);

  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_DIV - 1);

  logic [PW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          rx_bit_q;
  logic          sck_q;
  logic          busy_q;
  logic [7:0]    rx_q;
  logic          tick;
  logic          rise_evt;
  logic          fall_evt;

  assign tick     = busy_q && (ph_q == PH_LAST);
  assign rise_evt = tick && !sck_q;
  assign fall_evt = tick &&  sck_q;
  assign done     = fall_evt && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_bit_q <= 1'b0;
      sck_q    <= 1'b0;
      busy_q   <= 1'b0;
      rx_q     <= 8'h00;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= tx_byte;
        ph_q   <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
      end
    end else begin
      ph_q <= tick ? '0 : ph_q + 1'b1;
      if (rise_evt) begin
        sck_q    <= 1'b1;
        rx_bit_q <= miso;
      end
      if (fall_evt) begin
        sck_q <= 1'b0;
        sh_q  <= {sh_q[6:0], rx_bit_q};
        bit_q <= bit_q + 3'd1;
        if (done) begin
          busy_q <= 1'b0;
          rx_q   <= {sh_q[6:0], rx_bit_q};
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = busy_q ? sh_q[7] : 1'b1;
  assign busy    = busy_q;
  assign rx_byte = rx_q;

endmodule

// File: rtl/sdspi_engine.sv
module sdspi_engine
  import sdspi_pkg::*;
#(
  parameter int SCK_HALF_DIV = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sd_sck,
  output logic       sd_mosi,
  input  logic       sd_miso,
  output logic       sd_cs_n,
  input  logic       sd_detect,
  input  logic       sd_wprot,
  output logic       xfer_busy
);

  logic [1:0] stat_sync;
  logic       start_req;
  logic       start_fill;
  logic       start_evt;
  logic       xfer_done;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;

  sdspi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sd_wprot, sd_detect}),
    .d_out (stat_sync)
  );

  sdspi_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
    .busy       (xfer_busy),
    .cd_sync    (stat_sync[0]),
    .wp_sync    (stat_sync[1]),
    .rx_byte    (rx_byte),
    .start_req  (start_req),
    .start_fill (start_fill),
    .cs_n       (sd_cs_n),
    .rdata      (bus_rdata)
  );

  assign tx_byte   = start_fill ? FILL_BYTE : bus_wdata;
  assign start_evt = start_req && !xfer_busy;

  sdspi_shifter #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_req),
    .tx_byte (tx_byte),
    .miso    (sd_miso),
    .sck     (sd_sck),
    .mosi    (sd_mosi),
    .busy    (xfer_busy),
    .done    (xfer_done),
    .rx_byte (rx_byte)
  );

endmodule

// File: rtl/sdspi_engine_chk.sv
module sdspi_engine_chk
  import sdspi_pkg::*;
#(
  parameter int SCK_HALF_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       sd_sck,
  input logic       sd_mosi,
  input logic       sd_cs_n,
  input logic       xfer_busy,
  input logic       start_evt,
  input logic       xfer_done
);

  localparam int unsigned XFER = xfer_cycles(SCK_HALF_DIV);

  logic [31:0] run_cnt;
  logic        ctrl_wr;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= xfer_busy ? run_cnt + 32'd1 : 32'd0;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !sd_sck); // R4
  AST_MOSI_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> sd_mosi); // R4
  AST_MOSI_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sd_sck |-> $stable(sd_mosi)); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> xfer_busy); // R5
  AST_XFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> (run_cnt == 32'(XFER))); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_busy); // R8
  AST_CS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (sd_cs_n == $past(bus_wdata[0]))); // R2
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(sd_cs_n)); // R2

endmodule

bind sdspi_engine sdspi_engine_chk #(.SCK_HALF_DIV(SCK_HALF_DIV)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sd_sck    (sd_sck),
  .sd_mosi   (sd_mosi),
  .sd_cs_n   (sd_cs_n),
  .xfer_busy (xfer_busy),
  .start_evt (start_evt),
  .xfer_done (xfer_done)
);

// File: tb/sdspi_engine_tb.sv
module sdspi_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int XLEN       = 16 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sd_sck, sd_mosi, sd_miso, sd_cs_n, xfer_busy;
  logic       sd_detect = 1'b0;
  logic       sd_wprot = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int sck_rises = 0;
  bit done_flag = 1'b0;

  // SPI slave model
  logic [7:0] slv_tx = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  logic [7:0] slv_preset = 8'h00;
  logic       slv_load = 1'b0;

  assign sd_miso = slv_tx[7];

  always @(negedge sd_sck or posedge slv_load) begin
    if (slv_load) slv_tx <= slv_preset;
    else          slv_tx <= {slv_tx[6:0], 1'b0};
  end
  always @(posedge sd_sck) begin
    slv_rx <= {slv_rx[6:0], sd_mosi};
    sck_rises <= sck_rises + 1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdspi_engine #(.SCK_HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sd_sck(sd_sck), .sd_mosi(sd_mosi), .sd_miso(sd_miso), .sd_cs_n(sd_cs_n),
    .sd_detect(sd_detect), .sd_wprot(sd_wprot), .xfer_busy(xfer_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling clock edge.
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic preload_slave(input logic [7:0] b);
    slv_preset = b;
    slv_load = 1'b1;
    #1 slv_load = 1'b0;
  endtask

  // Waits (from the falling edge after the start edge) for busy to drop.
  task automatic wait_idle(input int c0, output int len);
    int guard = 0;
    while (xfer_busy && guard < 10 * XLEN) begin
      @(negedge clk);
      guard++;
    end
    len = cyc - c0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(sd_cs_n == 1'b1, "R1 cs_n", sd_cs_n, 1);
    chk(sd_sck == 1'b0 && sd_mosi == 1'b1, "R1 sck/mosi", {sd_sck, sd_mosi}, 1);
    chk(xfer_busy == 1'b0, "R1 busy", xfer_busy, 0);
    peek(2'd0, d); chk(d == 8'h01, "R1 ctrl", d, 8'h01);
    peek(2'd2, d); chk(d == 8'h00, "R1 data", d, 8'h00);
    peek(2'd1, d); chk(d[0] == 1'b0, "R1 stat busy", d, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_write(2'd0, 8'h06);
    chk(sd_cs_n == 1'b0, "R2 cs low", sd_cs_n, 0);
    peek(2'd0, d); chk(d == 8'h06, "R2 readback", d, 8'h06);
    bus_write(2'd0, 8'hFF);
    chk(sd_cs_n == 1'b1, "R2 cs high", sd_cs_n, 1);
    peek(2'd0, d); chk(d == 8'h07, "R2 upper bits", d, 8'h07);
    bus_read(2'd1, d);
    chk(sd_cs_n == 1'b1, "R2 cs untouched", sd_cs_n, 1);
    bus_write(2'd0, 8'h02);
    chk(sd_cs_n == 1'b0, "R2 select", sd_cs_n, 0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    sd_detect = 1'b1; sd_wprot = 1'b0;
    @(posedge clk); @(negedge clk);
    peek(2'd1, d); chk(d == 8'h00, "R3 one edge", d, 8'h00);
    @(posedge clk); @(negedge clk);
    peek(2'd1, d); chk(d == 8'h02, "R3 detect", d, 8'h02);
    sd_detect = 1'b0; sd_wprot = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    peek(2'd1, d); chk(d == 8'h04, "R3 wprot", d, 8'h04);
    sd_wprot = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_send(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] d;
    int c0, len, r0;
    preload_slave(rx);
    r0 = sck_rises;
    bus_write(2'd2, tx);
    c0 = cyc;
    chk(xfer_busy == 1'b1, "R5 busy rises", xfer_busy, 1);
    peek(2'd1, d); chk(d[0] == 1'b1, "R3 stat busy", d, 1);
    wait_idle(c0, len);
    chk(len == XLEN, "R5 length", len, XLEN);
    chk(sck_rises - r0 == 8, "R5 pulses", sck_rises - r0, 8);
    chk(slv_rx == tx, "R4 sent byte", slv_rx, tx);
    bus_read(2'd2, d);
    chk(d == rx, "R6 received byte", d, rx);
    chk(xfer_busy == 1'b0, "R6 read no start", xfer_busy, 0);
  endtask

  task automatic t_restart(input logic [7:0] rx_prev, input logic [7:0] rx);
    logic [7:0] d;
    int c0, len;
    preload_slave(rx);
    bus_read(2'd3, d);
    c0 = cyc;
    chk(d == rx_prev, "R7 previous byte", d, rx_prev);
    chk(xfer_busy == 1'b1, "R7 starts", xfer_busy, 1);
    wait_idle(c0, len);
    chk(len == XLEN, "R7 length", len, XLEN);
    chk(slv_rx == 8'hFF, "R7 sends FF", slv_rx, 8'hFF);
    peek(2'd3, d); chk(d == rx, "R7 new byte", d, rx);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    int c0, len;
    preload_slave(8'hC3);
    bus_write(2'd2, 8'h81);
    c0 = cyc;
    @(negedge clk);
    bus_write(2'd2, 8'h00);
    bus_read(2'd3, d);
    chk(xfer_busy == 1'b1, "R8 still busy", xfer_busy, 1);
    wait_idle(c0, len);
    chk(len == XLEN, "R8 length kept", len, XLEN);
    chk(slv_rx == 8'h81, "R8 byte kept", slv_rx, 8'h81);
    peek(2'd2, d); chk(d == 8'hC3, "R8 rx", d, 8'hC3);
    @(negedge clk);
    chk(xfer_busy == 1'b0, "R8 no late start", xfer_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_status();
    t_send(8'hA5, 8'h5A);
    t_send(8'h3C, 8'h96);
    t_send(8'h00, 8'hFF);
    t_restart(8'hFF, 8'h12);
    t_restart(8'h12, 8'hE7);
    t_ignore();
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule